// File: doc/BRIEF.md
# Write-Once Watchdog and Stop-Mode Guard

This block supervises a processor subsystem on the bus clock. It holds a small configuration register with three bits: watchdog enable, timeout length select, and stop-mode permission. After reset the register takes exactly one write. That write fixes all three bits until the next reset, so a program that goes astray cannot turn the watchdog off or allow stop mode later.

While the watchdog is enabled it counts bus clock cycles. It raises a one-cycle watchdog reset request if software does not pulse the service strobe before the selected period runs out. The short period is 2^SHORT_LOG2 cycles and the long period is 2^LONG_LOG2 cycles.

A separate guard watches the stop-request strobe. If stop mode has not been permitted, a stop request raises a one-cycle illegal-opcode reset request on its own output. The two request pulses are meant to feed an external reset controller.

Top module: `wdog_stop_guard`

## Requirements
- R1: After reset, cfg_rdata reads 3'b110 (bit 2 watchdog enable = 1, bit 1 long timeout = 1, bit 0 stop permitted = 0), and wdog_rst and illop_rst are low.
- R2: The first cfg_we cycle after reset loads cfg_wdata into the register, visible on cfg_rdata on the next cycle. Every later write is ignored until the next reset.
- R3: With the watchdog enabled, the long timeout selected and no service, wdog_rst goes high exactly 2^LONG_LOG2 clock edges after reset release.
- R4: With the short timeout selected (bit 1 = 0), wdog_rst goes high exactly 2^SHORT_LOG2 edges after the counter last started from zero.
- R5: A kick cycle clears the counter, so the next wdog_rst comes 2^period edges after the kick edge. A kick on the edge that would expire the counter suppresses that pulse.
- R6: While the watchdog is disabled (bit 2 = 0), the counter stays at zero and wdog_rst never asserts.
- R7: wdog_rst is high for one cycle only. Without service it repeats once every period.
- R8: A stop_req cycle while bit 0 is 0 gives a one-cycle illop_rst pulse on the next cycle. While bit 0 is 1, stop_req has no effect on illop_rst.
- R9: A reset reopens the register: the reset value returns and a new first write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Write data: bit 2 enable, bit 1 long timeout, bit 0 stop permitted |
| kick | input | 1 | Watchdog service strobe |
| stop_req | input | 1 | Stop instruction request strobe |
| cfg_rdata | output | 3 | Current configuration bits |
| wdog_rst | output | 1 | Watchdog reset request pulse |
| illop_rst | output | 1 | Illegal-opcode reset request pulse |

## Verification
The bench builds the block with SHORT_LOG2 = 4 and LONG_LOG2 = 6, which gives periods of 16 and 64 cycles. With these values it can check exact expiry cycles, repeated expiry, and a kick on the very edge of expiry within a few hundred cycles. The same values also allow a 200-cycle quiet window with the watchdog disabled, which is longer than three long periods.

// File: rtl/wdog_stop_guard.sv
`timescale 1ns/1ps
module wdog_stop_guard #(
  parameter int SHORT_LOG2 = 13,
  parameter int LONG_LOG2  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  input  logic       kick,
  input  logic       stop_req,
  output logic [2:0] cfg_rdata,
  output logic       wdog_rst,
  output logic       illop_rst
);
  localparam int CW = LONG_LOG2;
  localparam logic [CW-1:0] LONG_TOP  = '1;
  localparam logic [CW-1:0] SHORT_TOP = CW'((64'd1 << SHORT_LOG2) - 64'd1);

  logic          wd_en, long_sel, stop_ok, locked;
  logic [CW-1:0] cnt;
  logic [CW-1:0] top;
  logic          expire;

  assign top       = long_sel ? LONG_TOP : SHORT_TOP;
  assign expire    = wd_en && !kick && (cnt >= top);
  assign cfg_rdata = {wd_en, long_sel, stop_ok};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en    <= 1'b1;
      long_sel <= 1'b1;
      stop_ok  <= 1'b0;
      locked   <= 1'b0;
    end else if (cfg_we && !locked) begin
      {wd_en, long_sel, stop_ok} <= cfg_wdata;
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wdog_rst <= 1'b0;
    end else begin
      cnt      <= (!wd_en || kick || expire) ? '0 : cnt + 1'b1;
      wdog_rst <= expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illop_rst <= 1'b0;
    else        illop_rst <= stop_req && !stop_ok;
  end
endmodule

module wdog_stop_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kick,
  input logic       stop_req,
  input logic       locked,
  input logic [2:0] cfg_rdata,
  input logic       wdog_rst,
  input logic       illop_rst
);
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_rdata == 3'b110 && !wdog_rst && !illop_rst));
  p_lock_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_rdata));
  p_kick_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdog_rst);
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[2] |=> !wdog_rst);
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);
  p_bad_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !cfg_rdata[0]) |=> illop_rst);
  p_ok_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_req && !cfg_rdata[0]) |=> !illop_rst);
endmodule

bind wdog_stop_guard wdog_stop_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .stop_req(stop_req),
  .locked(locked), .cfg_rdata(cfg_rdata), .wdog_rst(wdog_rst),
  .illop_rst(illop_rst)
);

// File: tb/wdog_stop_guard_tb.sv
`timescale 1ns/1ps
module wdog_stop_guard_tb;
  localparam int SL = 4;
  localparam int LL = 6;
  localparam int SP = 1 << SL;
  localparam int LP = 1 << LL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic kick = 1'b0;
  logic stop_req = 1'b0;
  logic [2:0] cfg_rdata;
  logic wdog_rst, illop_rst;

  always #2 clk = ~clk;

  wdog_stop_guard #(.SHORT_LOG2(SL), .LONG_LOG2(LL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .kick(kick), .stop_req(stop_req), .cfg_rdata(cfg_rdata),
    .wdog_rst(wdog_rst), .illop_rst(illop_rst)
  );

  typedef struct {
    int cyc;
    logic [4:0] v;
    logic [4:0] m;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int c0 = 0;
  bit done = 1'b0;

  task automatic push(input int c, input logic [4:0] v, input logic [4:0] m, input string tag);
    item_t it;
    int pos;
    it.cyc = c; it.v = v; it.m = m; it.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++)
      if (q[i].cyc > c) begin pos = i; break; end
    q.insert(pos, it);
  endtask

  task automatic exp_w(input int c, input logic b, input string tag);
    push(c, {b, 4'b0}, 5'b10000, tag);
  endtask
  task automatic exp_i(input int c, input logic b, input string tag);
    push(c, {1'b0, b, 3'b0}, 5'b01000, tag);
  endtask
  task automatic exp_r(input int c, input logic [2:0] r, input string tag);
    push(c, {2'b0, r}, 5'b00111, tag);
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      logic [4:0] act;
      it = q.pop_front();
      act = {wdog_rst, illop_rst, cfg_rdata};
      checks++;
      if (it.cyc != cyc || (act & it.m) != (it.v & it.m)) begin
        fails++;
        $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                 it.tag, it.cyc, act & it.m, it.v & it.m, it.m);
      end
    end
  end

  task automatic go(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; kick = 1'b0; stop_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
  endtask

  task automatic write(input logic [2:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  initial begin
    // Defaults, long period, repeat, illegal stop
    do_reset();
    exp_r(c0 + 1, 3'b110, "R1");
    exp_w(c0 + 1, 1'b0, "R1");
    exp_i(c0 + 1, 1'b0, "R1");
    for (int k = 2; k < LP; k++) exp_w(c0 + k, 1'b0, "R3");
    exp_w(c0 + LP, 1'b1, "R3");
    exp_w(c0 + LP + 1, 1'b0, "R7");
    exp_w(c0 + 2 * LP - 1, 1'b0, "R7");
    exp_w(c0 + 2 * LP, 1'b1, "R7");
    exp_i(c0 + 11, 1'b1, "R8");
    exp_i(c0 + 12, 1'b0, "R8");
    go(c0 + 10);
    pulse_stop();
    go(c0 + 2 * LP + 2);

    // Write-once, short period, kicks, permitted stop
    do_reset();
    exp_r(c0 + 1, 3'b101, "R2");
    exp_r(c0 + 3, 3'b101, "R2");
    exp_w(c0 + SP - 1, 1'b0, "R4");
    exp_w(c0 + SP, 1'b1, "R4");
    exp_i(c0 + 21, 1'b0, "R8");
    exp_i(c0 + 22, 1'b0, "R8");
    exp_w(c0 + 32, 1'b0, "R5");
    exp_w(c0 + 46, 1'b0, "R5");
    exp_w(c0 + 61, 1'b0, "R5");
    exp_w(c0 + 62, 1'b1, "R5");
    write(3'b101);
    write(3'b010);
    go(c0 + 20);
    pulse_stop();
    go(c0 + 29);
    pulse_kick();
    go(c0 + 45);
    pulse_kick();
    go(c0 + 64);

    // Disabled watchdog
    do_reset();
    exp_r(c0 + 1, 3'b000, "R6");
    for (int k = 2; k <= 200; k++) exp_w(c0 + k, 1'b0, "R6");
    write(3'b000);
    go(c0 + 201);

    // Reset reopens the register
    do_reset();
    exp_r(c0 + 1, 3'b110, "R9");
    exp_r(c0 + 2, 3'b001, "R9");
    go(c0 + 1);
    write(3'b001);
    go(c0 + 5);

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule